// File: doc/BRIEF.md
# Level Capture Interrupt Block

This block watches a set of input lines that carry rare, important level indications, such as a warning that power is about to be removed. Each channel has an enable bit and a polarity bit. While a channel is enabled and its input sits at the active level, a sticky flag for that channel is set. The flag is set asynchronously by the input itself, so a level that comes and goes while the bus clock is stopped is still recorded.

Each flag passes through a two-flop synchroniser into the bus clock domain. Software reads the flags from a raw status register, or reads them ANDed with the enables from a masked status register. It removes a flag by writing a one to that channel's bit in a clear register. A single interrupt output is high while any masked flag is set.

Edge detection is not built into the hardware. Software can obtain it by flipping the polarity after each event.

Top module: `lvlcap_top`

## Requirements
- R1: After reset, all readable registers return 0 and `irq_o` is low.
- R2: The enable (offset 0x00), polarity (0x10) and mode (0x14) registers read back the value last written to their low NCH bits. Bits above NCH read 0. The clear register (0x0C) always reads 0.
- R3: With polarity bit 0, a high level on an enabled input sets that channel's raw flag (offset 0x04, bit n for channel n). The flag becomes visible in the raw status register two clock edges later, even when the pulse is shorter than one clock period.
- R4: With polarity bit 1, a low level on an enabled input sets the raw flag.
- R5: A channel whose enable bit is 0 does not capture its input.
- R6: A raw flag stays set after the input returns to its inactive level.
- R7: Writing the clear register clears the flags of the channels whose bits are 1 and leaves the other flags unchanged.
- R8: If a channel's active level is still present when its clear bit is written, the flag stays set.
- R9: The masked status register (0x08) reads raw status AND enable. `irq_o` is the OR of the masked status bits.
- R10: The mode register has no effect on capture.
- R11: A level that occurs while the clock is stopped is captured. It appears in raw status after the clock restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Monitored input levels, one per channel |
| bus_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The risky coincidence is a clear write that lands on the same edge as an input that is still active. The channel's asynchronous set must win, and the flag must not drop even for one cycle.

The bench holds channel 1 at its active level while writing its clear bit. It checks that raw status still shows the flag after the synchroniser delay. It then releases the input, clears again, and expects the flag to be gone.

A second overlap is a flag being set while the clock is stopped. The bench freezes the clock, pulses an input, restarts the clock, and checks the flag.

// File: rtl/lvlcap_pkg.sv
package lvlcap_pkg;
   // Register byte offsets; software decodes these positions.
   localparam logic [7:0] OFS_ENABLE = 8'h00;
   localparam logic [7:0] OFS_RAW    = 8'h04;
   localparam logic [7:0] OFS_MASKED = 8'h08;
   localparam logic [7:0] OFS_CLEAR  = 8'h0C;
   localparam logic [7:0] OFS_POL    = 8'h10;
   localparam logic [7:0] OFS_MODE   = 8'h14;
   localparam int unsigned MIN_ADDR_W = 5;
endpackage

// File: rtl/lvlcap_sync.sv
module lvlcap_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES != 2) begin : g_bad_stages
      $error("lvlcap_sync supports exactly two stages");
   end

   logic [W-1:0] stage1, stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         stage2 <= '0;
      end else begin
         stage1 <= d_i;
         stage2 <= stage1;
      end
   end

   assign q_o = stage2;

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      q_o == $past(d_i, 2)); // R3
endmodule

// File: rtl/lvlcap_chan.sv
module lvlcap_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic en_i,
   input  logic pol_i,
   input  logic clr_i,
   output logic flag_o
);
   // pol 0 -> active-high, pol 1 -> active-low
   logic hit;
   assign hit = en_i & (pin_i ^ pol_i);

   // Set is asynchronous: no clock edge is needed to record an event.
   always_ff @(posedge clk or negedge rst_n or posedge hit) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (hit)    flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R6
   AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && hit) |=> flag_o); // R8
endmodule

// File: rtl/lvlcap_regs.sv
module lvlcap_regs
   import lvlcap_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NCH-1:0]    raw_i,
   output logic [NCH-1:0]    en_o,
   output logic [NCH-1:0]    pol_o,
   output logic [NCH-1:0]    clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [NCH-1:0] mode_q;
   logic [NCH-1:0] wbits;
   logic sel_en, sel_raw, sel_msk, sel_clr, sel_pol, sel_mode;

   assign wbits    = bus_wdata[NCH-1:0];
   assign sel_en   = bus_addr == OFS_ENABLE[ADDR_W-1:0];
   assign sel_raw  = bus_addr == OFS_RAW[ADDR_W-1:0];
   assign sel_msk  = bus_addr == OFS_MASKED[ADDR_W-1:0];
   assign sel_clr  = bus_addr == OFS_CLEAR[ADDR_W-1:0];
   assign sel_pol  = bus_addr == OFS_POL[ADDR_W-1:0];
   assign sel_mode = bus_addr == OFS_MODE[ADDR_W-1:0];

   if (NCH < DATA_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NCH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         pol_o  <= '0;
         mode_q <= '0;
      end else if (bus_wr) begin
         if (sel_en)   en_o   <= wbits;
         if (sel_pol)  pol_o  <= wbits;
         if (sel_mode) mode_q <= wbits;
      end
   end

   // Clear is a single-cycle pulse sampled by the channels.
   assign clr_o = (bus_wr && sel_clr) ? wbits : '0;

   always_comb begin
      rdata_o = '0;
      unique case (1'b1)
         sel_en:   rdata_o[NCH-1:0] = en_o;
         sel_raw:  rdata_o[NCH-1:0] = raw_i;
         sel_msk:  rdata_o[NCH-1:0] = raw_i & en_o;
         sel_pol:  rdata_o[NCH-1:0] = pol_o;
         sel_mode: rdata_o[NCH-1:0] = mode_q;
         default:  rdata_o = '0;
      endcase
   end

   AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> bus_wr); // R7
endmodule

// File: rtl/lvlcap_top.sv
module lvlcap_top
   import lvlcap_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    pin_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("NCH must be between 1 and DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NCH-1:0] en, pol, clr, flag, raw_sync;

   lvlcap_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .raw_i(raw_sync), .en_o(en), .pol_o(pol),
      .clr_o(clr), .rdata_o(bus_rdata)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      lvlcap_chan u_chan (
         .clk(clk), .rst_n(rst_n), .pin_i(pin_i[i]), .en_i(en[i]),
         .pol_i(pol[i]), .clr_i(clr[i]), .flag_o(flag[i])
      );
   end

   lvlcap_sync #(.W(NCH), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(flag), .q_o(raw_sync)
   );

   assign irq_o = |(raw_sync & en);

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (raw_sync != '0)); // R9
endmodule

// File: tb/lvlcap_top_tb.sv
module lvlcap_top_tb;
   localparam int NCH = 8;
   localparam int AW  = 5;
   localparam int DW  = 32;

   logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
   logic [NCH-1:0] pins = 8'hF0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic irq;

   int compared = 0, mismatched = 0;
   bit finished = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb[$];

   lvlcap_top #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq)
   );

   initial forever begin
      #5;
      if (clk_run) clk = ~clk;
   end

   // Monitor: pops expected items and compares 2 ns after a falling edge.
   initial forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         act = it.is_irq ? {31'd0, irq} : bus_rdata;
         compared++;
         if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
      item_t it;
      @(negedge clk);
      bus_addr = a[AW-1:0];
      it.is_irq = 0; it.exp = e; it.req = r;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_irq(input bit e, input string r);
      item_t it;
      @(negedge clk);
      it.is_irq = 1; it.exp = {31'd0, e}; it.req = r;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse(input int ch);
      @(negedge clk);
      #1 pins[ch] = ~pins[ch];
      #3 pins[ch] = ~pins[ch];
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1");
      rd(8'h10, 0, "R1"); rd(8'h14, 0, "R1");
      rst_n = 1'b1;
      chk_irq(0, "R1");
      // R2 readback, upper bits dropped
      wr(8'h10, 32'h0000_00F0);
      wr(8'h14, 32'h1234_56A5);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'hFF, "R2"); rd(8'h10, 32'hF0, "R2");
      rd(8'h14, 32'hA5, "R2"); rd(8'h0C, 0, "R2");
      settle();
      rd(8'h04, 0, "R5");
      // R3 sub-cycle high pulse, R6 sticky
      pulse(0); settle();
      rd(8'h04, 32'h01, "R3"); rd(8'h08, 32'h01, "R9"); chk_irq(1, "R9");
      // R4 active-low pulse on ch5
      pulse(5); settle();
      rd(8'h04, 32'h21, "R4");
      // R5 disabled ch2
      wr(8'h00, 32'hFB); pulse(2); settle();
      rd(8'h04, 32'h21, "R5");
      wr(8'h00, 32'hFF);
      // R7 selective clear
      wr(8'h0C, 32'h01); settle();
      rd(8'h04, 32'h20, "R7");
      // R8 clear while active
      @(negedge clk); pins[1] = 1'b1; settle();
      wr(8'h0C, 32'h02); settle();
      rd(8'h04, 32'h22, "R8");
      @(negedge clk); pins[1] = 1'b0;
      wr(8'h0C, 32'h02); settle();
      rd(8'h04, 32'h20, "R8");
      // R10 mode irrelevant
      wr(8'h14, 32'h0); pulse(3); settle();
      rd(8'h04, 32'h28, "R10");
      // R9 masked follows enable
      wr(8'h00, 32'h00); settle();
      rd(8'h08, 32'h00, "R9"); chk_irq(0, "R9"); rd(8'h04, 32'h28, "R9");
      wr(8'h00, 32'hFF);
      // R11 capture with clock stopped
      @(negedge clk); clk_run = 1'b0;
      #20 pins[6] = 1'b0;
      #20 pins[6] = 1'b1;
      #20 clk_run = 1'b1;
      settle();
      rd(8'h04, 32'h68, "R11");
      // R7 clear all
      wr(8'h0C, 32'hFF); settle();
      rd(8'h04, 32'h00, "R7"); chk_irq(0, "R7");
      repeat (2) @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule